// File: doc/BRIEF.md
# Chained Codec Frame Sync Sequencer

This block sits on the master side of a serial port that several codecs share. Running on the serial bit clock, it splits time into word slots. The first slot belongs to the master device, and one further slot follows for each configured slave. At the start of every slot it raises a one-cycle frame sync toward the DSP. When chain mode is on, it also emits a delayed frame sync once per sequence, at the start of the first slave slot. That pulse becomes the frame sync of the first slave, and each slave passes its own delayed sync on to the next device.

An 8-bit control word sets four things: the number of slaves, a slot length of 16 or 32 bit clocks, a tag scheme on the data word LSB that lets the DSP tell the master word from slave words, and chain mode. Chain mode changes the roles of two pins. With chain mode off, pin A is an input (its driver is disabled) and pin B carries an active-low ring indication. With chain mode on, pin A drives the ring indication with a programmable polarity and pin B carries the delayed frame sync. After a primary sequence, a secondary sequence of the same shape follows if one is requested. The control word is captured only at the start of each primary sequence.

Top module: `chain_fsync_ctrl`

## Requirements
- R1: While reset is held low, and until the first bit clock edge after it is released, fsync_dsp, pin_a_oe, pin_a_out, lsb_tag and sec_frame are 0, and the captured control word reads as all zeros, so pin_b_out equals the inverse of ring_in.
- R2: From the first clock edge after reset release, fsync_dsp is high for exactly one cycle at the first bit of every slot, and the master slot is the first slot of every sequence.
- R3: A slot lasts 16 bit clocks when ctrl[2] is 0 and 32 bit clocks when ctrl[2] is 1.
- R4: A sequence has 1 + N slots, where N = ctrl[7:5] (0 to 7).
- R5: ctrl[0] selects chain mode. With chain mode on, pin_a_oe is 1 and pin_b_out pulses high for one cycle, together with fsync_dsp, at the first bit of slot 1 of each sequence. With chain mode off, pin_a_oe is 0, pin_a_out is 0 and pin_b_out is the inverse of ring_in.
- R6: With chain mode on, pin_a_out equals ring_in when ctrl[1] is 1 and the inverse of ring_in when ctrl[1] is 0.
- R7: When N is 0, pin_b_out never pulses, even with chain mode on.
- R8: lsb_tag holds for the whole slot. ctrl[4:3]=00 gives 0 in every slot. Values 01 and 11 give 1 in the master slot and 0 in slave slots. Value 10 gives 0 in the master slot and 1 in slave slots.
- R9: If sec_req is high in the last bit clock of a primary sequence, a secondary sequence with the same slot count and length follows at once, with sec_frame high throughout it. A new primary sequence always follows a secondary one.
- R10: A change to ctrl takes effect only at the first bit of the next primary sequence. The start of a secondary sequence does not capture it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl | input | 8 | Control word: [7:5] slave count, [4:3] tag scheme, [2] long slot, [1] ring polarity, [0] chain mode |
| sec_req | input | 1 | Request for a secondary sequence, sampled at the end of a primary sequence |
| ring_in | input | 1 | Active-high ring indication from the line side |
| fsync_dsp | output | 1 | Frame sync toward the DSP, one pulse per slot |
| pin_a_out | output | 1 | Pin A data: ring indication in chain mode |
| pin_a_oe | output | 1 | Pin A driver enable, high in chain mode |
| pin_b_out | output | 1 | Pin B: delayed frame sync in chain mode, active-low ring otherwise |
| lsb_tag | output | 1 | LSB tag value for the word of the current slot |
| sec_frame | output | 1 | High during a secondary sequence |

## Verification
The embedded properties assume that ctrl and sec_req are sampled only at bit clock edges, that rst_n is held low from time zero, and that no slot is shorter than two bit clocks. Under those conditions the sync pulses cannot merge and the gap counter gives a correct spacing. The stimulus changes ctrl, sec_req and ring_in only at falling edges and holds reset low for several cycles before releasing it. Control words are sometimes changed partway through a sequence, so that the capture-at-primary-start rule is tested against slot spacing and count.

// File: rtl/cfs_pkg.sv
// Package: shared control-word layout and tag helper for the chained
// frame sync sequencer. Assumes an 8-bit control word whose field order
// matches the struct below (bit 0 is the least significant field).
package cfs_pkg;

    typedef struct packed {
        logic [2:0] nslv;      // number of slave slots after the master
        logic [1:0] tag_mode;  // LSB tagging scheme
        logic       long_slot; // 1: 32-clock slots, 0: 16-clock slots
        logic       rpol;      // ring polarity in chain mode (1 = active-high)
        logic       chain;     // chain mode enable
    } cfs_cfg_t;

    // Tag value for one slot under a given scheme.
    function automatic logic tag_bit(input logic [1:0] mode, input logic is_master);
        logic t;
        case (mode)
            2'b00:   t = 1'b0;
            2'b10:   t = ~is_master;
            default: t = is_master;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/cfs_slot_timer.sv
// Module: bit and slot counters plus the control capture register.
// Walks slots of SHORT_SLOT or LONG_SLOT bit clocks, master slot first,
// then nslv slave slots; optionally repeats once as a secondary sequence.
// Assumes ctrl_in and sec_req are synchronous to clk.
module cfs_slot_timer
    import cfs_pkg::*;
#(
    parameter int SHORT_SLOT = 16,
    parameter int LONG_SLOT  = 32,
    localparam int CNT_W     = $clog2(LONG_SLOT),
    localparam int SLOT_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cfs_cfg_t          ctrl_in,
    input  logic              sec_req,
    output logic              run,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              sec_phase,
    output cfs_cfg_t          cfg
);

    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_SLOT - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_SLOT - 1);

    logic              run_q;
    logic [CNT_W-1:0]  bit_q;
    logic [SLOT_W-1:0] slot_q;
    logic              sec_q;
    cfs_cfg_t          cfg_q;
    logic [CNT_W-1:0]  last_bit;
    logic              slot_end;
    logic              seq_end;

    // Decode end of slot and end of sequence from the captured config.
    always_comb begin
        last_bit = cfg_q.long_slot ? LONG_LAST : SHORT_LAST;
        slot_end = (bit_q == last_bit);
        seq_end  = slot_end && (slot_q == cfg_q.nslv);
    end

    // Advance counters; capture control at each primary sequence start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            bit_q  <= '0;
            slot_q <= '0;
            sec_q  <= 1'b0;
            cfg_q  <= '0;
        end else if (!run_q || seq_end) begin
            run_q  <= 1'b1;
            bit_q  <= '0;
            slot_q <= '0;
            if (run_q && !sec_q && sec_req) begin
                sec_q <= 1'b1;
            end else begin
                sec_q <= 1'b0;
                cfg_q <= ctrl_in;
            end
        end else if (slot_end) begin
            bit_q  <= '0;
            slot_q <= slot_q + 1'b1;
        end else begin
            bit_q  <= bit_q + 1'b1;
        end
    end

    assign run       = run_q;
    assign bit_cnt   = bit_q;
    assign slot_idx  = slot_q;
    assign sec_phase = sec_q;
    assign cfg       = cfg_q;

    AST_CFG_AT_PRIMARY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !$stable(cfg_q)) |-> (bit_q == '0 && slot_q == '0 && !sec_q)); // R10

    AST_SLOT_WITHIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (slot_q <= cfg_q.nslv)); // R4

endmodule

// File: rtl/cfs_sync_gen.sv
// Module: frame sync, delayed sync and LSB tag generation from the slot
// position. Assumes slots of at least two bit clocks and that cfg only
// changes at the first bit of a primary sequence.
module cfs_sync_gen
    import cfs_pkg::*;
#(
    parameter int SHORT_SLOT = 16,
    parameter int LONG_SLOT  = 32,
    localparam int CNT_W     = $clog2(LONG_SLOT),
    localparam int GAP_W     = $clog2(LONG_SLOT + 1),
    localparam int SLOT_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic              sec_phase,
    input  cfs_cfg_t          cfg,
    output logic              fsync,
    output logic              fsd,
    output logic              lsb_tag,
    output logic              sec_frame
);

    // Pulses at slot starts and per-slot tag value.
    always_comb begin
        fsync     = run && (bit_cnt == '0);
        fsd       = fsync && cfg.chain && (cfg.nslv != '0) && (slot_idx == SLOT_W'(1));
        lsb_tag   = run && tag_bit(cfg.tag_mode, slot_idx == '0);
        sec_frame = run && sec_phase;
    end

    // Checker state: cycles since last sync, its expected spacing, master tag.
    logic [GAP_W-1:0] gap_q;
    logic [GAP_W-1:0] sp_q;
    logic             have_prev_q;
    logic             master_tag_q;

    // Track the spacing between consecutive frame syncs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q       <= '0;
            sp_q        <= '0;
            have_prev_q <= 1'b0;
        end else if (fsync) begin
            gap_q       <= GAP_W'(1);
            sp_q        <= cfg.long_slot ? GAP_W'(LONG_SLOT) : GAP_W'(SHORT_SLOT);
            have_prev_q <= 1'b1;
        end else if (gap_q != GAP_W'(LONG_SLOT)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // Remember the tag driven during the master slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_tag_q <= 1'b0;
        end else if (run && slot_idx == '0) begin
            master_tag_q <= lsb_tag;
        end
    end

    AST_FSYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> !fsync); // R2

    AST_FSYNC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync && have_prev_q) |-> (gap_q == sp_q)); // R3

    AST_TAG_MASTER_DIFFERS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && slot_idx != '0 && cfg.tag_mode != 2'b00) |-> (lsb_tag != master_tag_q)); // R8

endmodule

// File: rtl/cfs_pin_mux.sv
// Module: pin role selection. In chain mode pin A drives ring indication
// with programmable polarity and pin B carries the delayed sync; otherwise
// pin A is released and pin B shows an active-low ring indication.
// Assumes ring_in is active-high.
module cfs_pin_mux
    import cfs_pkg::*;
(
    input  cfs_cfg_t cfg,
    input  logic     ring_in,
    input  logic     fsd,
    output logic     pin_a_out,
    output logic     pin_a_oe,
    output logic     pin_b_out
);

    // Route ring and delayed sync according to the captured mode.
    always_comb begin
        if (cfg.chain) begin
            pin_a_oe  = 1'b1;
            pin_a_out = cfg.rpol ? ring_in : ~ring_in;
            pin_b_out = fsd;
        end else begin
            pin_a_oe  = 1'b0;
            pin_a_out = 1'b0;
            pin_b_out = ~ring_in;
        end
    end

endmodule

// File: rtl/chain_fsync_ctrl.sv
// Module: top of the chained codec frame sync sequencer. Connects the slot
// timer, the sync generator and the pin role mux. Assumes all inputs are
// synchronous to the serial bit clock.
module chain_fsync_ctrl
    import cfs_pkg::*;
#(
    parameter int SHORT_SLOT = 16,
    parameter int LONG_SLOT  = 32,
    localparam int CNT_W     = $clog2(LONG_SLOT),
    localparam int SLOT_W    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] ctrl,
    input  logic       sec_req,
    input  logic       ring_in,
    output logic       fsync_dsp,
    output logic       pin_a_out,
    output logic       pin_a_oe,
    output logic       pin_b_out,
    output logic       lsb_tag,
    output logic       sec_frame
);

    logic              run;
    logic [CNT_W-1:0]  bit_cnt;
    logic [SLOT_W-1:0] slot_idx;
    logic              sec_phase;
    cfs_cfg_t          cfg;
    logic              fsd;

    cfs_slot_timer #(.SHORT_SLOT(SHORT_SLOT), .LONG_SLOT(LONG_SLOT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_in   (cfs_cfg_t'(ctrl)),
        .sec_req   (sec_req),
        .run       (run),
        .bit_cnt   (bit_cnt),
        .slot_idx  (slot_idx),
        .sec_phase (sec_phase),
        .cfg       (cfg)
    );

    cfs_sync_gen #(.SHORT_SLOT(SHORT_SLOT), .LONG_SLOT(LONG_SLOT)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .bit_cnt   (bit_cnt),
        .slot_idx  (slot_idx),
        .sec_phase (sec_phase),
        .cfg       (cfg),
        .fsync     (fsync_dsp),
        .fsd       (fsd),
        .lsb_tag   (lsb_tag),
        .sec_frame (sec_frame)
    );

    cfs_pin_mux u_pins (
        .cfg       (cfg),
        .ring_in   (ring_in),
        .fsd       (fsd),
        .pin_a_out (pin_a_out),
        .pin_a_oe  (pin_a_oe),
        .pin_b_out (pin_b_out)
    );

    AST_DELAYED_SYNC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_a_oe && pin_b_out) |-> fsync_dsp); // R5

endmodule

// File: tb/tb_chain_fsync_ctrl.sv
`timescale 1ns/100ps
module tb_chain_fsync_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ctrl = 8'h00;
    logic       sec_req = 1'b0;
    logic       ring_in = 1'b0;
    logic       fsync_dsp, pin_a_out, pin_a_oe, pin_b_out, lsb_tag, sec_frame;

    int n_vec = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // Independent model of the requirements.
    bit       m_run;
    int       m_bit, m_slot;
    bit       m_sec;
    bit [7:0] m_cfg;

    always #2.5 clk = ~clk;

    chain_fsync_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .sec_req(sec_req), .ring_in(ring_in),
        .fsync_dsp(fsync_dsp), .pin_a_out(pin_a_out), .pin_a_oe(pin_a_oe),
        .pin_b_out(pin_b_out), .lsb_tag(lsb_tag), .sec_frame(sec_frame)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update at a rising edge (R3 spacing, R4 count, R9 secondary, R10 capture).
    task automatic model_step();
        int sp;
        sp = m_cfg[2] ? 32 : 16;
        if (!rst_n) begin
            m_run = 0; m_bit = 0; m_slot = 0; m_sec = 0; m_cfg = 8'h00;
        end else if (!m_run || (m_bit == sp - 1 && m_slot == int'(m_cfg[7:5]))) begin
            if (m_run && !m_sec && sec_req) m_sec = 1;
            else begin m_sec = 0; m_cfg = ctrl; end
            m_run = 1; m_bit = 0; m_slot = 0;
        end else if (m_bit == sp - 1) begin
            m_bit = 0; m_slot++;
        end else begin
            m_bit++;
        end
    endtask

    task automatic compare(input string scen);
        logic e_fs, e_fsd, e_pb, e_pa, e_oe, e_tag, e_sec;
        e_fs  = m_run && m_bit == 0;
        e_fsd = e_fs && m_cfg[0] && m_cfg[7:5] != 0 && m_slot == 1;
        e_oe  = m_cfg[0];
        e_pa  = m_cfg[0] ? (m_cfg[1] ? ring_in : ~ring_in) : 1'b0;
        e_pb  = m_cfg[0] ? e_fsd : ~ring_in;
        case (m_cfg[4:3])
            2'b00:   e_tag = 1'b0;
            2'b10:   e_tag = m_run && m_slot != 0;
            default: e_tag = m_run && m_slot == 0;
        endcase
        e_sec = m_run && m_sec;
        chk({scen, " R2/R3/R4 fsync_dsp"}, fsync_dsp, e_fs);
        chk({scen, " R5/R7 pin_b_out"}, pin_b_out, e_pb);
        chk({scen, " R5/R6 pin_a_out"}, pin_a_out, e_pa);
        chk({scen, " R5 pin_a_oe"}, pin_a_oe, e_oe);
        chk({scen, " R8 lsb_tag"}, lsb_tag, e_tag);
        chk({scen, " R9 sec_frame"}, sec_frame, e_sec);
    endtask

    task automatic tick(input string scen);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(scen);
    endtask

    task automatic run_cycles(input string scen, input int n);
        for (int i = 0; i < n; i++) begin
            ring_in = (i % 7 == 2) || (i % 5 == 0);
            #0.1;
            tick(scen);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; ctrl = 8'hFF; ring_in = 1'b1;
        for (int i = 0; i < 4; i++) tick("R1 reset");
        chk("R1 fsync_dsp in reset", fsync_dsp, 1'b0);
        chk("R1 pin_a_oe in reset", pin_a_oe, 1'b0);
        chk("R1 pin_b_out in reset", pin_b_out, 1'b0);
        chk("R1 lsb_tag in reset", lsb_tag, 1'b0);
        ring_in = 1'b0; #0.1;
        chk("R1 pin_b_out follows ring low", pin_b_out, 1'b1);
    endtask

    task automatic t_basic();
        int pulses = 0;
        ctrl = 8'h4B;          // N=2, tag 01, short, rpol=1, chain on
        rst_n = 1'b1;
        tick("R2 first");
        chk("R2 master sync right after reset", fsync_dsp, 1'b1);
        chk("R8 master tag", lsb_tag, 1'b1);
        for (int i = 0; i < 95; i++) begin
            tick("basic");
            if (fsync_dsp) pulses++;
        end
        chk("R4 six slot syncs in 96 cycles", pulses == 5, 1'b1);
    endtask

    task automatic t_long();
        ctrl = 8'hF5;          // N=7, tag 10, long, rpol=0, chain on
        run_cycles("R3 long slots", 8 * 32 * 2 + 40);
    endtask

    task automatic t_no_slaves();
        int b_pulses = 0;
        ctrl = 8'h19;          // N=0, tag 11, short, chain on
        for (int i = 0; i < 120; i++) begin
            tick("R7 no slaves");
            if (pin_b_out) b_pulses++;
        end
        chk("R7 no delayed sync with N=0", b_pulses == 0, 1'b1);
    endtask

    task automatic t_secondary();
        int sec_cycles = 0;
        ctrl = 8'h2B;          // N=1, tag 01, short, rpol=1, chain on
        sec_req = 1'b1;
        for (int i = 0; i < 200; i++) begin
            tick("R9 secondary");
            if (sec_frame) sec_cycles++;
        end
        sec_req = 1'b0;
        chk("R9 secondary sequences occurred", sec_cycles >= 64, 1'b1);
        run_cycles("R9 after", 80);
    endtask

    task automatic t_ctrl_change();
        ctrl = 8'h6B;          // N=3 short
        run_cycles("R10 setup", 37);
        ctrl = 8'h0C;          // mid-sequence: N=0 long, chain off
        run_cycles("R10 mid change", 90);
        sec_req = 1'b1;
        ctrl = 8'h45;
        run_cycles("R10 change before secondary", 200);
        sec_req = 1'b0;
    endtask

    task automatic t_chain_off();
        ctrl = 8'h60;          // N=3 chain off, tag 00
        run_cycles("R5 chain off", 150);
        ring_in = 1'b1; #0.1;
        chk("R5 pin_b_out active-low ring", pin_b_out, 1'b0);
        chk("R5 pin_a released", pin_a_oe, 1'b0);
    endtask

    task automatic t_polarity();
        ctrl = 8'h01;          // chain on, rpol=0
        run_cycles("R6 polarity low", 40);
        ring_in = 1'b1; #0.1;
        chk("R6 active-low ring on pin A", pin_a_out, 1'b0);
        ctrl = 8'h03;          // rpol=1
        run_cycles("R6 polarity high", 40);
        ring_in = 1'b1; #0.1;
        chk("R6 active-high ring on pin A", pin_a_out, 1'b1);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_long();
        t_no_slaves();
        t_secondary();
        t_ctrl_change();
        t_chain_off();
        t_polarity();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule